// File: doc/BRIEF.md
# Paged DMA Transfer Controller

This block copies a run of 32-bit words between a single attached I/O device and system memory, so the processor does not have to move each word itself. Software fills in a start address and a byte count through a small bank of memory-mapped registers, then writes the command register with a device number, a direction and the start bit. The controller asks for the memory bus and moves the words back to back while it holds the grant. At every 4 KiB page boundary it lets go of the bus.

The address that software programs is used as a physical address and is never translated. A transfer that spans several pages is carried out as a sequence of page-bounded pieces, one after another. Each piece needs a bus acquisition of its own, and the request is dropped for at least one cycle between pieces so that other masters can win the bus. Normal completion and an error both raise the interrupt line and set a status bit. Software clears the bit by writing a 1 to it.

The device side is always ready. In the device-to-memory direction the controller pulses a pop strobe and takes the word the device presents. In the memory-to-device direction it pulses a push strobe together with the word it has read.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: After reset, every register reads as zero, `irq` is low and `bus_req` is low. The register indices are 0 command, 1 address, 2 byte count, 3 status and 4 fault address.
- R2: A command write with bit 0 set, while the controller is idle and the byte count is a nonzero multiple of 4, starts a transfer. The transfer moves count/4 words at consecutive word addresses, beginning at the programmed address with its two low bits forced to zero and no other change.
- R3: Command bit 1 selects the direction. With 0 (device to memory), each word is taken from `dev_rdata` on a `dev_pop` pulse, in order, and written with `mem_we` high. With 1 (memory to device), each word is read with `mem_we` low and delivered on `dev_wdata` with a `dev_push` pulse, and `dev_pop` never pulses.
- R4: A transfer never runs through a 4 KiB page boundary while holding the bus. After the last word below a boundary, `bus_req` goes low for at least one cycle and then rises again for the next piece, so an N-page span uses N bus acquisitions.
- R5: No memory access is issued until `bus_gnt` is high. Once `mem_valid` is raised, it and `mem_addr` stay unchanged until `mem_ready`.
- R6: When the last word completes, the busy bit (status bit 0) clears, the done bit (status bit 1) sets and `irq` rises, all at the same clock edge.
- R7: A start with a byte count that is not a multiple of 4 sets the error bit (status bit 2) and raises `irq` at once, and never requests the bus.
- R8: A start with a byte count of zero sets the done bit at once and never requests the bus.
- R9: A memory response with `mem_err` stops the transfer at that word. The controller releases the bus, sets the error bit, raises `irq` and stores the failing word's address in the fault address register.
- R10: Writing status with bit 1 or bit 2 set clears that bit, and `irq` falls once neither bit is left set. An accepted start also clears both bits.
- R11: While busy, a write to the command register has no effect: the running transfer keeps its direction, device number, address and length.
- R12: The device number in command bits 7:4 is driven on `dev_sel` from the moment the start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data of the indexed register |
| irq | output | 1 | Interrupt, high while done or error is set |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_valid | output | 1 | Memory access valid |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | ADDR_W | Word-aligned physical address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access complete this cycle |
| mem_err | input | 1 | Error response, qualified by mem_ready |
| mem_rdata | input | 32 | Read data, qualified by mem_ready |
| dev_sel | output | DEV_W | Selected device number |
| dev_pop | output | 1 | Take one word from the device |
| dev_rdata | input | 32 | Word presented by the device |
| dev_push | output | 1 | Deliver one word to the device |
| dev_wdata | output | 32 | Word delivered to the device |

## Verification
The hardest cases to reach are the page-boundary splits. The stimulus starts transfers a few words below a boundary, and in one case the run spans a complete 1024-word page plus parts of the pages on either side, so the bench can count exactly three bus acquisitions and confirm the address sequence runs without a break across the boundaries. Two other states cannot be set up through the registers alone. To hold a transfer busy before its first word, the bench withholds the grant; it uses that window both to show that nothing moves and to send a conflicting start command. To stop a transfer in mid-stream, the bench injects a bus error at one chosen address and then checks the words already moved and the recorded fault address.

// File: rtl/dma_pkg.sv
// Shared constants and types for the paged DMA transfer controller.
// Assumes 32-bit data words and a byte-addressed memory.
package dma_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_SHIFT = 2;

    // register indices
    localparam logic [2:0] SEL_CMD   = 3'd0;
    localparam logic [2:0] SEL_ADDR  = 3'd1;
    localparam logic [2:0] SEL_COUNT = 3'd2;
    localparam logic [2:0] SEL_STAT  = 3'd3;
    localparam logic [2:0] SEL_FAULT = 3'd4;

    // command and status bit positions
    localparam int CMD_START   = 0;
    localparam int CMD_DIR     = 1;
    localparam int CMD_DEV_LSB = 4;
    localparam int STAT_BUSY   = 0;
    localparam int STAT_DONE   = 1;
    localparam int STAT_ERR    = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_FETCH,
        ST_ACCESS,
        ST_GAP
    } dma_state_e;
endpackage

// File: rtl/dma_regs.sv
// Software-visible register bank. It holds the command, address, count,
// status and fault-address registers, filters start requests and drives
// the interrupt. Assumes DEV_W <= 28, ADDR_W <= 32 and CNT_W <= 32.
module dma_regs
    import dma_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              fin,
    input  logic              fault,
    input  logic [ADDR_W-1:0] fault_addr_in,
    output logic              go,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              dir,
    output logic [DEV_W-1:0]  dev,
    output logic              irq
);
    logic              done_q, err_q;
    logic [ADDR_W-1:0] fault_q;
    logic              cmd_wr, start_req, len_bad, len_zero, stat_wr;
    logic              unused_wdata;

    assign unused_wdata = ^cfg_wdata;

    // decode an accepted command write and classify the programmed length
    always_comb begin
        cmd_wr    = cfg_we && (cfg_sel == SEL_CMD) && !busy;
        start_req = cmd_wr && cfg_wdata[CMD_START];
        len_bad   = |byte_cnt[WORD_SHIFT-1:0];
        len_zero  = (byte_cnt == '0);
        go        = start_req && !len_bad && !len_zero;
        stat_wr   = cfg_we && (cfg_sel == SEL_STAT);
        irq       = done_q || err_q;
    end

    // programmable registers: command, address and count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir       <= 1'b0;
            dev       <= '0;
            base_addr <= '0;
            byte_cnt  <= '0;
        end else begin
            if (cmd_wr) begin
                dir <= cfg_wdata[CMD_DIR];
                dev <= cfg_wdata[CMD_DEV_LSB +: DEV_W];
            end
            if (cfg_we && cfg_sel == SEL_ADDR)
                base_addr <= {cfg_wdata[ADDR_W-1:WORD_SHIFT], {WORD_SHIFT{1'b0}}};
            if (cfg_we && cfg_sel == SEL_COUNT)
                byte_cnt <= cfg_wdata[CNT_W-1:0];
        end
    end

    // status bits: a start clears them, write-1 clears them, events set them
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            fault_q <= '0;
        end else if (start_req) begin
            done_q <= len_zero && !len_bad;
            err_q  <= len_bad;
        end else begin
            if (stat_wr && cfg_wdata[STAT_DONE]) done_q <= 1'b0;
            if (stat_wr && cfg_wdata[STAT_ERR])  err_q  <= 1'b0;
            if (fin) done_q <= 1'b1;
            if (fault) begin
                err_q   <= 1'b1;
                fault_q <= fault_addr_in;
            end
        end
    end

    // read multiplexer for the indexed register
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_CMD: begin
                cfg_rdata[CMD_DIR]                = dir;
                cfg_rdata[CMD_DEV_LSB +: DEV_W]   = dev;
            end
            SEL_ADDR:  cfg_rdata[ADDR_W-1:0] = base_addr;
            SEL_COUNT: cfg_rdata[CNT_W-1:0]  = byte_cnt;
            SEL_STAT: begin
                cfg_rdata[STAT_BUSY] = busy;
                cfg_rdata[STAT_DONE] = done_q;
                cfg_rdata[STAT_ERR]  = err_q;
            end
            SEL_FAULT: cfg_rdata[ADDR_W-1:0] = fault_q;
            default:   cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dma_chunk.sv
// Sizes the next piece of a transfer: the smaller of the words still to
// move and the words left before the next page boundary. Purely
// combinational. Assumes the address is word aligned and
// WCNT_W >= PAGE_BITS - 1.
module dma_chunk #(
    parameter int PAGE_BITS = 12,
    parameter int WCNT_W    = 14
) (
    input  logic [PAGE_BITS-1:0] page_off,
    input  logic [WCNT_W-1:0]    rem_words,
    output logic [WCNT_W-1:0]    chunk_words
);
    localparam int WSH = dma_pkg::WORD_SHIFT;

    logic [PAGE_BITS:0] to_end_bytes;
    logic [WCNT_W-1:0]  to_end_words;

    // distance to the page end, then clip it to the remaining length
    always_comb begin
        to_end_bytes = (PAGE_BITS+1)'(1 << PAGE_BITS) - {1'b0, page_off};
        to_end_words = WCNT_W'(to_end_bytes[PAGE_BITS:WSH]);
        chunk_words  = (rem_words < to_end_words) ? rem_words : to_end_words;
    end
endmodule

// File: rtl/dma_engine.sv
// Transfer sequencer. It acquires the bus for each page-bounded piece,
// moves the words one access at a time, releases the bus between pieces,
// and reports completion or a faulting access. Assumes the device side
// is always ready and that the grant stays high while the request is held.
module dma_engine
    import dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-WORD_SHIFT-1:0] word_cnt,
    input  logic              dir,
    output logic              busy,
    output logic              fin,
    output logic              fault,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              dev_pop,
    input  logic [WORD_W-1:0] dev_rdata,
    output logic              dev_push,
    output logic [WORD_W-1:0] dev_wdata
);
    localparam int WCNT_W = CNT_W - WORD_SHIFT;
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(1 << WORD_SHIFT);

    dma_state_e        st;
    logic [ADDR_W-1:0] cur_addr;
    logic [WCNT_W-1:0] rem, chunk_left, chunk_w;
    logic [WORD_W-1:0] wbuf;
    logic              acc_done, acc_ok, last_all, last_piece;

    dma_chunk #(.PAGE_BITS(PAGE_BITS), .WCNT_W(WCNT_W)) u_chunk (
        .page_off    (cur_addr[PAGE_BITS-1:0]),
        .rem_words   (rem),
        .chunk_words (chunk_w)
    );

    // access completion and end-of-piece / end-of-transfer decode
    always_comb begin
        acc_done   = (st == ST_ACCESS) && mem_ready;
        acc_ok     = acc_done && !mem_err;
        last_all   = (rem == WCNT_W'(1));
        last_piece = (chunk_left == WCNT_W'(1));
        fin        = acc_ok && last_all;
        fault      = acc_done && mem_err;
        fault_addr = cur_addr;
    end

    // bus, memory and device outputs from the current state
    always_comb begin
        busy      = (st != ST_IDLE);
        bus_req   = (st == ST_REQ) || (st == ST_FETCH) || (st == ST_ACCESS);
        mem_valid = (st == ST_ACCESS);
        mem_we    = !dir;
        mem_addr  = cur_addr;
        mem_wdata = wbuf;
        dev_pop   = (st == ST_FETCH);
        dev_push  = acc_ok && dir;
        dev_wdata = mem_rdata;
    end

    // sequencer: request, optional device fetch, access, gap between pieces
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            cur_addr   <= '0;
            rem        <= '0;
            chunk_left <= '0;
            wbuf       <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    cur_addr <= base_addr;
                    rem      <= word_cnt;
                    st       <= ST_REQ;
                end
                ST_REQ: if (bus_gnt) begin
                    chunk_left <= chunk_w;
                    st         <= dir ? ST_ACCESS : ST_FETCH;
                end
                ST_FETCH: begin
                    wbuf <= dev_rdata;
                    st   <= ST_ACCESS;
                end
                ST_ACCESS: if (mem_ready) begin
                    if (mem_err) begin
                        st <= ST_IDLE;
                    end else begin
                        cur_addr   <= cur_addr + WORD_STEP;
                        rem        <= rem - WCNT_W'(1);
                        chunk_left <= chunk_left - WCNT_W'(1);
                        if (last_all)        st <= ST_IDLE;
                        else if (last_piece) st <= ST_GAP;
                        else                 st <= dir ? ST_ACCESS : ST_FETCH;
                    end
                end
                ST_GAP:  st <= ST_REQ;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dma_xfer_ctrl.sv
// Top of the paged DMA transfer controller: joins the register bank and
// the transfer sequencer. Assumes a single bus master interface and one
// always-ready device port.
module dma_xfer_ctrl
    import dma_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 16,
    parameter int DEV_W     = 4,
    parameter int PAGE_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic [DEV_W-1:0]  dev_sel,
    output logic              dev_pop,
    input  logic [31:0]       dev_rdata,
    output logic              dev_push,
    output logic [31:0]       dev_wdata
);
    logic              eng_busy, eng_fin, eng_fault, eng_go, cfg_dir;
    logic [ADDR_W-1:0] eng_fault_addr, cfg_base;
    logic [CNT_W-1:0]  cfg_count;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_sel       (cfg_sel),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .busy          (eng_busy),
        .fin           (eng_fin),
        .fault         (eng_fault),
        .fault_addr_in (eng_fault_addr),
        .go            (eng_go),
        .base_addr     (cfg_base),
        .byte_cnt      (cfg_count),
        .dir           (cfg_dir),
        .dev           (dev_sel),
        .irq           (irq)
    );

    dma_engine #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (eng_go),
        .base_addr  (cfg_base),
        .word_cnt   (cfg_count[CNT_W-1:WORD_SHIFT]),
        .dir        (cfg_dir),
        .busy       (eng_busy),
        .fin        (eng_fin),
        .fault      (eng_fault),
        .fault_addr (eng_fault_addr),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .mem_valid  (mem_valid),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ready  (mem_ready),
        .mem_err    (mem_err),
        .mem_rdata  (mem_rdata),
        .dev_pop    (dev_pop),
        .dev_rdata  (dev_rdata),
        .dev_push   (dev_push),
        .dev_wdata  (dev_wdata)
    );
endmodule

// File: rtl/dma_xfer_chk.sv
// Protocol checker for the paged DMA transfer controller, attached to
// the top module by the bind below. It observes only; it drives nothing.
module dma_xfer_chk #(
    parameter int PAGE_BITS = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_req,
    input logic                 bus_gnt,
    input logic                 mem_valid,
    input logic                 mem_ready,
    input logic                 mem_err,
    input logic [PAGE_BITS-1:0] page_addr,
    input logic                 irq,
    input logic                 busy
);
    // R5: an access is only presented while the bus is requested and granted
    a_r5_access_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (bus_req && bus_gnt));

    // R5: a stalled access holds its address until it is accepted
    a_r5_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(page_addr)));

    // R2: every access is word aligned
    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (page_addr[1:0] == 2'b00));

    // R4: the last word below a page boundary releases the bus next cycle
    a_r4_release_at_page_end: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && !mem_err && (&page_addr[PAGE_BITS-1:2])) |=> !bus_req);

    // R9: an error response stops the transfer and interrupts
    a_r9_error_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && mem_err) |=> (!bus_req && irq && !busy));

    // R6: the end of a transfer always leaves the interrupt raised
    a_r6_irq_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);
endmodule

bind dma_xfer_ctrl dma_xfer_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_err   (mem_err),
    .page_addr (mem_addr[PAGE_BITS-1:0]),
    .irq       (irq),
    .busy      (eng_busy)
);

// File: tb/sim_dma_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_dma_xfer_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq, bus_req, bus_gnt, mem_valid, mem_we, mem_ready, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata, dev_rdata, dev_wdata;
    logic [3:0]  dev_sel;
    logic        dev_pop, dev_push;

    // bench controls
    logic        gnt_en = 1'b1, stall_en = 1'b0, err_en = 1'b0, mon_clr = 1'b0;
    logic [31:0] err_addr = '0, tb_base = '0;
    logic        tb_dir = 1'b0;
    logic        stall_tick = 1'b0, req_d = 1'b0;
    int          tests = 0, fails = 0;
    int          mon_k = 0, mon_bad = 0, mon_acq = 0, mon_push = 0, mon_pop = 0, mon_err = 0;
    int          dev_cnt = 0;

    always #4 clk = ~clk;

    assign bus_gnt   = bus_req && gnt_en;
    assign mem_ready = mem_valid && (!stall_en || stall_tick);
    assign mem_err   = mem_ready && err_en && (mem_addr == err_addr);
    assign mem_rdata = mem_addr ^ 32'h5A5A_5A5A;
    assign dev_rdata = 32'hD000_0000 + 32'(dev_cnt);

    dma_xfer_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_valid(mem_valid),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .dev_sel(dev_sel), .dev_pop(dev_pop), .dev_rdata(dev_rdata),
        .dev_push(dev_push), .dev_wdata(dev_wdata)
    );

    // bus and device monitor: compares every moved word with the expected stream
    always @(posedge clk) begin
        stall_tick <= ~stall_tick;
        req_d      <= bus_req;
        if (mon_clr) begin
            mon_k <= 0; mon_bad <= 0; mon_acq <= 0; mon_push <= 0;
            mon_pop <= 0; mon_err <= 0; dev_cnt <= 0;
        end else begin
            if (bus_req && !req_d) mon_acq <= mon_acq + 1;
            if (dev_pop) begin
                mon_pop <= mon_pop + 1;
                dev_cnt <= dev_cnt + 1;
            end
            if (mem_valid && mem_ready) begin
                if (mem_err) mon_err <= mon_err + 1;
                else begin
                    mon_k <= mon_k + 1;
                    if (mem_addr != tb_base + 32'(4 * mon_k) || mem_we != !tb_dir ||
                        (mem_we && mem_wdata != 32'hD000_0000 + 32'(mon_k)) ||
                        (dev_push && dev_wdata != ((tb_base + 32'(4 * mon_k)) ^ 32'h5A5A_5A5A)))
                        mon_bad <= mon_bad + 1;
                end
            end
            if (dev_push) mon_push <= mon_push + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] sel, output logic [31:0] data);
        @(negedge clk);
        cfg_sel = sel;
        #1 data = cfg_rdata;
    endtask

    task automatic clear_mon(input logic [31:0] base, input logic dir);
        @(negedge clk);
        tb_base = base; tb_dir = dir; mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            cfg_read(3'd3, s);
            if (!s[0]) break;
        end
    endtask

    task automatic start_xfer(input logic [31:0] base, input logic [31:0] cnt,
                              input logic dir, input logic [3:0] dev);
        clear_mon(base, dir);
        cfg_write(3'd1, base);
        cfg_write(3'd2, cnt);
        cfg_write(3'd0, {24'd0, dev, 2'b00, dir, 1'b1});
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 5; s++) begin
            cfg_read(3'(s), v);
            chk("R1 register after reset", v, 32'd0);
        end
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 bus_req after reset", {31'd0, bus_req}, 32'd0);
    endtask

    task automatic t_dev_to_mem();
        logic [31:0] v;
        start_xfer(32'h0000_2000, 32'd64, 1'b0, 4'd5);
        chk("R12 dev_sel follows command", {28'd0, dev_sel}, 32'd5);
        wait_idle();
        chk("R2 words moved", 32'(mon_k), 32'd16);
        chk("R3 device-to-memory stream", 32'(mon_bad), 32'd0);
        chk("R3 pops per word", 32'(mon_pop), 32'd16);
        chk("R4 single piece acquisitions", 32'(mon_acq), 32'd1);
        cfg_read(3'd3, v);
        chk("R6 status done", v, 32'd2);
        chk("R6 irq on done", {31'd0, irq}, 32'd1);
        cfg_write(3'd3, 32'd2);
        cfg_read(3'd3, v);
        chk("R10 done cleared", v, 32'd0);
        chk("R10 irq cleared", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_mem_to_dev();
        start_xfer(32'h0000_3013, 32'd32, 1'b1, 4'd2);
        stall_en = 1'b1;
        tb_base  = 32'h0000_3010;
        wait_idle();
        stall_en = 1'b0;
        chk("R5 R3 memory-to-device stream", 32'(mon_bad), 32'd0);
        chk("R3 pushes per word", 32'(mon_push), 32'd8);
        chk("R3 no pops when reading memory", 32'(mon_pop), 32'd0);
        cfg_write(3'd3, 32'd6);
    endtask

    task automatic t_page_split();
        start_xfer(32'h0000_4FF0, 32'd40, 1'b0, 4'd1);
        wait_idle();
        chk("R4 words across one boundary", 32'(mon_k), 32'd10);
        chk("R4 stream across one boundary", 32'(mon_bad), 32'd0);
        chk("R4 two acquisitions", 32'(mon_acq), 32'd2);
        cfg_write(3'd3, 32'd6);
        start_xfer(32'h0000_5FF8, 32'h0000_1010, 1'b0, 4'd1);
        wait_idle();
        chk("R4 words across full page", 32'(mon_k), 32'd1028);
        chk("R4 stream across full page", 32'(mon_bad), 32'd0);
        chk("R4 three acquisitions", 32'(mon_acq), 32'd3);
        cfg_write(3'd3, 32'd6);
    endtask

    task automatic t_grant_wait();
        logic [31:0] v;
        gnt_en = 1'b0;
        start_xfer(32'h0000_A000, 32'd8, 1'b1, 4'd3);
        repeat (20) @(negedge clk);
        chk("R5 nothing moves without grant", 32'(mon_k + mon_push), 32'd0);
        chk("R5 request held while waiting", {31'd0, bus_req}, 32'd1);
        cfg_read(3'd3, v);
        chk("R5 busy while waiting", v, 32'd1);
        gnt_en = 1'b1;
        wait_idle();
        chk("R5 words after grant", 32'(mon_push), 32'd2);
        cfg_write(3'd3, 32'd6);
    endtask

    task automatic t_misaligned();
        logic [31:0] v;
        start_xfer(32'h0000_B000, 32'd6, 1'b0, 4'd0);
        cfg_read(3'd3, v);
        chk("R7 error on odd count", v, 32'd4);
        chk("R7 irq on odd count", {31'd0, irq}, 32'd1);
        repeat (5) @(negedge clk);
        chk("R7 no bus request", 32'(mon_acq), 32'd0);
        cfg_write(3'd3, 32'd4);
        cfg_read(3'd3, v);
        chk("R10 error cleared", v, 32'd0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        start_xfer(32'h0000_C000, 32'd0, 1'b0, 4'd0);
        cfg_read(3'd3, v);
        chk("R8 zero count done", v, 32'd2);
        repeat (5) @(negedge clk);
        chk("R8 no bus request", 32'(mon_acq), 32'd0);
        cfg_write(3'd3, 32'd2);
    endtask

    task automatic t_bus_err();
        logic [31:0] v;
        err_addr = 32'h0000_8014;
        err_en   = 1'b1;
        start_xfer(32'h0000_8000, 32'd64, 1'b0, 4'd7);
        wait_idle();
        err_en = 1'b0;
        chk("R9 words before error", 32'(mon_k), 32'd5);
        chk("R9 one failing access", 32'(mon_err), 32'd1);
        cfg_read(3'd3, v);
        chk("R9 status error", v, 32'd4);
        chk("R9 irq on error", {31'd0, irq}, 32'd1);
        chk("R9 bus released", {31'd0, bus_req}, 32'd0);
        cfg_read(3'd4, v);
        chk("R9 fault address", v, 32'h0000_8014);
        cfg_write(3'd3, 32'd4);
        chk("R10 irq cleared after error", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_start_busy();
        logic [31:0] v;
        gnt_en = 1'b0;
        start_xfer(32'h0000_9000, 32'd16, 1'b0, 4'd6);
        repeat (3) @(negedge clk);
        cfg_write(3'd0, {24'd0, 4'd9, 2'b00, 1'b1, 1'b1});
        cfg_read(3'd0, v);
        chk("R11 command unchanged while busy", v, 32'h0000_0060);
        chk("R11 dev_sel unchanged", {28'd0, dev_sel}, 32'd6);
        gnt_en = 1'b1;
        wait_idle();
        chk("R11 original length kept", 32'(mon_k), 32'd4);
        chk("R11 original direction kept", 32'(mon_bad), 32'd0);
        chk("R11 single acquisition", 32'(mon_acq), 32'd1);
        cfg_write(3'd3, 32'd6);
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #(8 * 190000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dev_to_mem();
        t_mem_to_dev();
        t_page_split();
        t_grant_wait();
        t_misaligned();
        t_zero();
        t_bus_err();
        t_start_busy();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule